// File: doc/BRIEF.md
# Repeat-Mode BCD Alarm Comparator

This block decides, once per second, whether the current calendar time has reached a programmed alarm time. The time counters outside the block present five BCD fields (month, date, hours, minutes, seconds) and raise a one-cycle second strobe each time those fields advance. The alarm fields are compared with them only on that strobe. A 5-bit repeat code selects how many fields take part, starting from seconds and growing upward. A match latches an alarm flag and, when the interrupt enables allow it, drives an active-low interrupt request.

Reading the flags register releases the interrupt. The flag still shows as set during the read that clears it and reads as zero on any later read. While the system runs from its backup supply, the interrupt also needs a separate backup enable. Both enables are held inside the block. They are loaded through a configuration strobe and cleared by reset, which stands for power-up. An alarm that arrives straight after power-up therefore only sets the flag.

Top module: `alarm_match_unit`

## Requirements
- R1: The repeat code `rpt_code` (bit 4 down to bit 0) picks the compared fields. 11111 compares none, so every strobe fires. 11110 compares seconds. 11100 compares minutes and seconds. 11000 adds hours. 10000 adds date. 00000 compares month, date, hours, minutes and seconds.
- R2: Any repeat code other than the six in R1 behaves like 11111 and fires on every strobe.
- R3: A match on a strobe sets `alarm_flag`. `irq_n` goes low on that match only when the interrupt enable is 1.
- R4: A cycle with `flag_rd` high and no matching strobe clears both the flag and the interrupt at its clock edge. During that read cycle `alarm_flag` still shows 1. A match in the same cycle as a read takes priority and keeps the flag set.
- R5: While `on_battery` is 1, a match drives `irq_n` low only when both the interrupt enable and the backup enable are 1. Otherwise only the flag is set.
- R6: Reset clears both enables, the flag and the interrupt. A match that follows reset with no enable write sets the flag and leaves `irq_n` high.
- R7: With `rpt_code` = 00000 and `alm_date` = 00h the alarm is disabled. No strobe sets the flag, whatever the time fields hold.
- R8: Matches are evaluated only in cycles where `sec_tick` is 1. The flag and the interrupt change at the clock edge that samples the strobe. Equal fields with no strobe have no effect.
- R9: `cfg_we` loads `cfg_irq_en` and `cfg_bkup_en` into the enable registers at the clock edge. A match in the same cycle still uses the previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| sec_tick | input | 1 | One-cycle strobe after the time fields advance |
| cur_mon | input | 8 | Current month, BCD |
| cur_date | input | 8 | Current date, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_sec | input | 8 | Current seconds, BCD |
| alm_mon | input | 8 | Alarm month, BCD |
| alm_date | input | 8 | Alarm date, BCD |
| alm_hour | input | 8 | Alarm hours, BCD |
| alm_min | input | 8 | Alarm minutes, BCD |
| alm_sec | input | 8 | Alarm seconds, BCD |
| rpt_code | input | 5 | Repeat code |
| cfg_we | input | 1 | Load strobe for the two enables |
| cfg_irq_en | input | 1 | New interrupt enable value |
| cfg_bkup_en | input | 1 | New backup interrupt enable value |
| flag_rd | input | 1 | Flags register read strobe |
| on_battery | input | 1 | System is running from backup supply |
| alarm_flag | output | 1 | Alarm flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench targets these corner cases:
- A design that reversed the thermometer would fire a per-minute alarm only on a full date match. The bench catches this with a minute code whose date, hour and minute fields deliberately differ.
- An unlisted code that fell into the yearly case would stay silent instead of firing.
- The read that clears the flag is checked in its own cycle, where the flag must still show 1. A flag cleared combinationally would show 0 there.
- A read that lands on a matching strobe must not drop the new alarm.
- The disable pattern is driven with a current date of 00h. A design that ignored the disable would fire on the yearly match.
- Backup mode is run with the backup enable both off and on.
- Equal fields are held for several cycles with no strobe, and the flag must stay clear.

// File: rtl/alm_pkg.sv
// Package: shared constants and types for the alarm comparator.
// Assumes five BCD fields ordered from seconds (index 0) up to month (index 4).
package alm_pkg;
    localparam int NFIELDS = 5;
    localparam int FIELD_W = 8;
    localparam int CODE_W  = 5;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DATE = 3;
    localparam int F_MON  = 4;

    // Repeat mode; the numeric value is the count of low fields compared.
    typedef enum logic [2:0] {
        RM_EVERY_SEC   = 3'd0,
        RM_EVERY_MIN   = 3'd1,
        RM_EVERY_HOUR  = 3'd2,
        RM_EVERY_DAY   = 3'd3,
        RM_EVERY_MONTH = 3'd4,
        RM_EVERY_YEAR  = 3'd5
    } rpt_mode_e;

    typedef logic [NFIELDS-1:0][FIELD_W-1:0] field_vec_t;
endpackage

// File: rtl/alm_rpt_decode.sv
// Module: alm_rpt_decode
// Turns the 5-bit repeat code into a repeat mode and a per-field compare mask.
// Assumes mask bit i covers field index i (seconds first). Unlisted codes fall
// back to the every-second mode.
module alm_rpt_decode
    import alm_pkg::*;
#(
    parameter int N_FIELDS = NFIELDS,
    parameter int C_W      = CODE_W
) (
    input  logic [C_W-1:0]      code,
    output rpt_mode_e           mode,
    output logic [N_FIELDS-1:0] mask
);
    // Map legal thermometer codes to modes, everything else to every-second.
    always_comb begin
        case (code)
            5'b11111: mode = RM_EVERY_SEC;
            5'b11110: mode = RM_EVERY_MIN;
            5'b11100: mode = RM_EVERY_HOUR;
            5'b11000: mode = RM_EVERY_DAY;
            5'b10000: mode = RM_EVERY_MONTH;
            5'b00000: mode = RM_EVERY_YEAR;
            default:  mode = RM_EVERY_SEC;
        endcase
    end

    // Field i is compared when the mode covers more than i low fields.
    for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_mask
        assign mask[gi] = (gi < int'(mode));
    end
endmodule

// File: rtl/alm_field_cmp.sv
// Module: alm_field_cmp
// Compares the masked time fields against the alarm fields and reports a hit.
// Assumes both field vectors are stable in the cycle where the result is used.
module alm_field_cmp
    import alm_pkg::*;
#(
    parameter int N_FIELDS = NFIELDS,
    parameter int W        = FIELD_W
) (
    input  logic [N_FIELDS-1:0][W-1:0] cur_v,
    input  logic [N_FIELDS-1:0][W-1:0] alm_v,
    input  logic [N_FIELDS-1:0]        mask,
    input  logic                       disabled,
    output logic                       hit
);
    logic [N_FIELDS-1:0] field_ok;

    // A field passes when it is excluded or equal to its alarm value.
    for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_eq
        assign field_ok[gi] = !mask[gi] || (cur_v[gi] == alm_v[gi]);
    end

    // Combine all fields and apply the disable pattern.
    always_comb begin
        hit = (&field_ok) && !disabled;
    end
endmodule

// File: rtl/alm_flag_ctrl.sv
// Module: alm_flag_ctrl
// Holds the enables, the alarm flag and the interrupt state.
// Assumes match is only meaningful when tick is high; a match beats a read.
module alm_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic rd,
    input  logic on_battery,
    input  logic cfg_we,
    input  logic cfg_irq_en,
    input  logic cfg_bkup_en,
    output logic flag_q,
    output logic irq_q,
    output logic irq_en_q,
    output logic bkup_en_q
);
    logic fire;
    logic irq_allowed;

    // Decide whether this cycle raises an alarm and whether it may interrupt.
    always_comb begin
        fire        = tick && match;
        irq_allowed = irq_en_q && (!on_battery || bkup_en_q);
    end

    // Enable registers: cleared at power-up, loaded by the config strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q  <= 1'b0;
            bkup_en_q <= 1'b0;
        end else if (cfg_we) begin
            irq_en_q  <= cfg_irq_en;
            bkup_en_q <= cfg_bkup_en;
        end
    end

    // Flag and interrupt: set on an alarm, released by a flags read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else if (fire) begin
            flag_q <= 1'b1;
            irq_q  <= irq_q || irq_allowed;
        end else if (rd) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/alarm_match_unit.sv
// Module: alarm_match_unit (top)
// Once-per-second BCD alarm comparator with repeat modes, flag and interrupt.
// Assumes the time fields are already updated in the cycle sec_tick is high.
module alarm_match_unit
    import alm_pkg::*;
#(
    parameter int W   = FIELD_W,
    parameter int C_W = CODE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sec_tick,
    input  logic [W-1:0]   cur_mon,
    input  logic [W-1:0]   cur_date,
    input  logic [W-1:0]   cur_hour,
    input  logic [W-1:0]   cur_min,
    input  logic [W-1:0]   cur_sec,
    input  logic [W-1:0]   alm_mon,
    input  logic [W-1:0]   alm_date,
    input  logic [W-1:0]   alm_hour,
    input  logic [W-1:0]   alm_min,
    input  logic [W-1:0]   alm_sec,
    input  logic [C_W-1:0] rpt_code,
    input  logic           cfg_we,
    input  logic           cfg_irq_en,
    input  logic           cfg_bkup_en,
    input  logic           flag_rd,
    input  logic           on_battery,
    output logic           alarm_flag,
    output logic           irq_n
);
    localparam int NF = NFIELDS;

    logic [NF-1:0][W-1:0] cur_v;
    logic [NF-1:0][W-1:0] alm_v;
    logic [NF-1:0]        cmp_mask;
    rpt_mode_e            mode;
    logic                 disabled;
    logic                 hit;
    logic                 flag_q;
    logic                 irq_q;
    logic                 irq_en_q;
    logic                 bkup_en_q;

    // Pack the individual fields in compare order, seconds first.
    always_comb begin
        cur_v[F_SEC]  = cur_sec;
        cur_v[F_MIN]  = cur_min;
        cur_v[F_HOUR] = cur_hour;
        cur_v[F_DATE] = cur_date;
        cur_v[F_MON]  = cur_mon;
        alm_v[F_SEC]  = alm_sec;
        alm_v[F_MIN]  = alm_min;
        alm_v[F_HOUR] = alm_hour;
        alm_v[F_DATE] = alm_date;
        alm_v[F_MON]  = alm_mon;
    end

    // Zero repeat code together with a zero alarm date disables the alarm.
    always_comb begin
        disabled = (rpt_code == '0) && (alm_date == '0);
    end

    alm_rpt_decode #(.N_FIELDS(NF), .C_W(C_W)) u_decode (
        .code (rpt_code),
        .mode (mode),
        .mask (cmp_mask)
    );

    alm_field_cmp #(.N_FIELDS(NF), .W(W)) u_cmp (
        .cur_v    (cur_v),
        .alm_v    (alm_v),
        .mask     (cmp_mask),
        .disabled (disabled),
        .hit      (hit)
    );

    alm_flag_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (sec_tick),
        .match       (hit),
        .rd          (flag_rd),
        .on_battery  (on_battery),
        .cfg_we      (cfg_we),
        .cfg_irq_en  (cfg_irq_en),
        .cfg_bkup_en (cfg_bkup_en),
        .flag_q      (flag_q),
        .irq_q       (irq_q),
        .irq_en_q    (irq_en_q),
        .bkup_en_q   (bkup_en_q)
    );

    // Drive the outputs; the interrupt pin is active low.
    always_comb begin
        alarm_flag = flag_q;
        irq_n      = !irq_q;
    end
endmodule

// File: rtl/alm_match_chk.sv
// Module: alm_match_chk
// Temporal checks on the alarm comparator, attached to the top by bind.
module alm_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       flag_rd,
    input logic       on_battery,
    input logic [4:0] rpt_code,
    input logic [7:0] alm_date,
    input logic       alarm_flag,
    input logic       irq_n,
    input logic       afe_q,
    input logic       abe_q
);
    // R3: the interrupt is never active without the flag.
    assert_irq_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> alarm_flag);

    // R3: the interrupt can only start when the interrupt enable was set.
    assert_irq_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(afe_q));

    // R4: a read with no strobe leaves the flag and interrupt clear.
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !sec_tick) |=> (!alarm_flag && irq_n));

    // R5: in backup mode the interrupt also needs the backup enable.
    assert_backup_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_n) && $past(on_battery)) |-> $past(abe_q));

    // R6: leaving reset, enables and flag are clear.
    assert_reset_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!afe_q && !abe_q && !alarm_flag && irq_n));

    // R7: the disable pattern never raises a clear flag.
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_code == 5'b00000 && alm_date == 8'h00 && !alarm_flag) |=> !alarm_flag);

    // R8: the flag only rises after a cycle holding the strobe.
    assert_only_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(sec_tick));
endmodule

bind alarm_match_unit alm_match_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .flag_rd    (flag_rd),
    .on_battery (on_battery),
    .rpt_code   (rpt_code),
    .alm_date   (alm_date),
    .alarm_flag (alarm_flag),
    .irq_n      (irq_n),
    .afe_q      (irq_en_q),
    .abe_q      (bkup_en_q)
);

// File: tb/test_alarm_match_unit.sv
module test_alarm_match_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sec_tick, cfg_we, cfg_irq_en, cfg_bkup_en, flag_rd, on_battery;
    logic [7:0] cur [5];
    logic [7:0] alm [5];
    logic [4:0] rpt_code;
    logic       alarm_flag, irq_n;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;
    logic       afe_m = 0, abe_m = 0;

    always #10 clk = ~clk;

    alarm_match_unit i_alarm_match_unit (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_mon(cur[4]), .cur_date(cur[3]), .cur_hour(cur[2]),
        .cur_min(cur[1]), .cur_sec(cur[0]),
        .alm_mon(alm[4]), .alm_date(alm[3]), .alm_hour(alm[2]),
        .alm_min(alm[1]), .alm_sec(alm[0]),
        .rpt_code(rpt_code), .cfg_we(cfg_we), .cfg_irq_en(cfg_irq_en),
        .cfg_bkup_en(cfg_bkup_en), .flag_rd(flag_rd), .on_battery(on_battery),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    // Number of low fields (seconds upward) a repeat code compares.
    function automatic int fields_used(input logic [4:0] c);
        case (c)
            5'b11110: return 1;
            5'b11100: return 2;
            5'b11000: return 3;
            5'b10000: return 4;
            5'b00000: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic logic exp_hit();
        if (rpt_code == 5'b00000 && alm[3] == 8'h00) return 1'b0;
        for (int i = 0; i < fields_used(rpt_code); i++)
            if (cur[i] != alm[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #2;
    endtask

    task automatic set_en(input logic a, input logic b);
        cfg_we = 1; cfg_irq_en = a; cfg_bkup_en = b;
        cycle();
        cfg_we = 0;
        afe_m = a; abe_m = b;
    endtask

    task automatic clear_flag();
        flag_rd = 1;
        cycle();
        flag_rd = 0;
    endtask

    task automatic tick_once();
        sec_tick = 1;
        cycle();
        sec_tick = 0;
    endtask

    task automatic match_all();
        for (int i = 0; i < 5; i++) cur[i] = alm[i];
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        logic e;
        logic [4:0] codes [7];
        codes = '{5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000, 5'b00000, 5'b01010};
        void'($urandom(32'd1234));
        rst_n = 0; sec_tick = 0; cfg_we = 0; cfg_irq_en = 0; cfg_bkup_en = 0;
        flag_rd = 0; on_battery = 0; rpt_code = 5'b00000;
        alm = '{8'h30, 8'h45, 8'h12, 8'h15, 8'h06};
        cur = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01};
        repeat (3) cycle();
        rst_n = 1;
        cycle();
        chk("R6 reset flag", alarm_flag, 1'b0);
        chk("R6 reset irq_n", irq_n, 1'b1);

        // R6: match right after reset sets only the flag
        match_all(); tick_once();
        chk("R6 flag after power-up alarm", alarm_flag, 1'b1);
        chk("R6 no irq after power-up alarm", irq_n, 1'b1);

        // R4: read cycle still shows the flag, then cleared
        flag_rd = 1; #1;
        chk("R4 flag visible during clearing read", alarm_flag, 1'b1);
        cycle(); flag_rd = 0;
        chk("R4 flag cleared after read", alarm_flag, 1'b0);

        // R9 / R3: enable interrupt; yearly code with month mismatch
        set_en(1, 0);
        cur[4] = 8'h07; tick_once();
        chk("R1 yearly month mismatch", alarm_flag, 1'b0);
        match_all(); tick_once();
        chk("R3 flag on yearly match", alarm_flag, 1'b1);
        chk("R3 R9 irq with enable", irq_n, 1'b0);
        clear_flag();
        chk("R4 irq released by read", irq_n, 1'b1);

        // R1: per-minute code needs only seconds
        rpt_code = 5'b11110;
        cur = '{8'h30, 8'h00, 8'h00, 8'h02, 8'h03};
        tick_once();
        chk("R1 minute code seconds only", alarm_flag, 1'b1);
        clear_flag();
        cur[0] = 8'h31; tick_once();
        chk("R1 minute code seconds differ", alarm_flag, 1'b0);

        // R2: illegal code fires with nothing equal
        rpt_code = 5'b10101;
        cur = '{8'h59, 8'h59, 8'h23, 8'h31, 8'h12};
        tick_once();
        chk("R2 illegal code fires", alarm_flag, 1'b1);
        clear_flag();

        // R8: equal fields with no strobe do nothing
        rpt_code = 5'b00000; match_all();
        repeat (4) cycle();
        chk("R8 no strobe no flag", alarm_flag, 1'b0);
        chk("R8 no strobe no irq", irq_n, 1'b1);

        // R7: disable pattern with date 00
        alm[3] = 8'h00; match_all(); tick_once();
        chk("R7 disabled alarm silent", alarm_flag, 1'b0);
        alm[3] = 8'h15;

        // R5: backup mode gating
        on_battery = 1; match_all(); tick_once();
        chk("R5 backup flag set", alarm_flag, 1'b1);
        chk("R5 backup no irq without backup enable", irq_n, 1'b1);
        clear_flag();
        set_en(1, 1); tick_once();
        chk("R5 backup irq with both enables", irq_n, 1'b0);
        clear_flag();
        on_battery = 0;

        // R4: match during read wins
        flag_rd = 1; sec_tick = 1; cycle(); flag_rd = 0; sec_tick = 0;
        chk("R4 match beats read", alarm_flag, 1'b1);
        clear_flag();

        // Random trials against the model
        for (int t = 0; t < 400; t++) begin
            if (t % 7 == 0) set_en(1'($urandom), 1'($urandom));
            on_battery = 1'($urandom);
            rpt_code = ($urandom % 4 == 0) ? 5'($urandom) : codes[$urandom % 7];
            for (int i = 0; i < 5; i++) begin
                alm[i] = 8'($urandom % 10) | (8'($urandom % 3) << 4);
                cur[i] = ($urandom % 4 == 0) ? alm[i] ^ 8'h01 : alm[i];
            end
            if ($urandom % 10 == 0) begin alm[3] = 8'h00; cur[3] = 8'h00; end
            e = exp_hit();
            tick_once();
            chk("R1 R2 R7 random flag", alarm_flag, e);
            chk("R3 R5 random irq_n", irq_n, !(e && afe_m && (!on_battery || abe_m)));
            clear_flag();
        end

        done = 1;
        summary();
    end
endmodule